// File: doc/BRIEF.md
# Interleaved Three-Slot Manchester Line Encoder

This block merges two one-bit pulse-density streams and a self-generated alternating pattern onto one Manchester-coded serial line. Every four system clocks it sends one coded bit. Bits are sent in repeating three-cell frames. The first cell of each frame carries an alternating marker bit. The second carries a sample of channel 0 and the third carries a sample of channel 1. A receiver can lock onto the marker cell and then take out each channel at one third of the line bit rate.

A single active-high run input serves as both enable and synchronous reset. While run is low, the block is in shutdown: the line rests low and all frame state is cleared. The first clock edge that samples run high starts the first cell, which is always a marker cell carrying 0. A one-clock frame strobe marks the start of each marker cell, so logic nearby can align to frames without decoding the line.

Top module: `mce_frame_encoder`

## Requirements
- R1: At every clock edge that samples run low, line_out and frame_start both go to 0 and stay at 0 while run remains low.
- R2: Each coded cell lasts exactly 4 clocks. Let edge E0 be the first edge that samples run high after shutdown. Cell n starts at edge E0+4n.
- R3: A cell carrying bit value 1 drives line_out low for its first 2 clocks and high for its last 2. A cell carrying 0 drives high and then low. The line therefore always changes level at the cell midpoint.
- R4: Cell n carries slot (n mod 3). Slot 0 is the marker, slot 1 is channel 0 and slot 2 is channel 1. The order never changes, and both channel slots are always sent.
- R5: The marker bit of frame f (cells 3f) equals f mod 2. The first marker after shutdown is 0, and the marker bit inverts from one frame to the next.
- R6: A channel cell carries the value its input had at the edge that starts that cell. Changes to the input during the rest of the cell have no effect on the line.
- R7: frame_start is 1 for exactly the first clock of every marker cell and 0 at all other times.
- R8: Dropping run at any phase of any cell and raising it again restarts the frame at a marker cell carrying 0, with the cell timing of R2 counted from the new E0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| run | input | 1 | High: encode. Low: shutdown and synchronous clear |
| ch0_in | input | 1 | Pulse-density stream of channel 0 |
| ch1_in | input | 1 | Pulse-density stream of channel 1 |
| line_out | output | 1 | Manchester-coded serial line |
| frame_start | output | 1 | One-clock strobe at the start of each marker cell |

## Verification
Two functions can act on the same edge. One is the shutdown clear. The other is the cell-start load, which would pick the next slot and flip the marker. The bench provokes this by ending run windows of every length from 20 to 31 cycles, so run falls at each of the four cell phases and in each of the three slots. After each window it checks that the line and the strobe are low and that the next window restarts with a 0 marker cell at the new first edge. Channel inputs change on every clock in some windows. Each channel cell is then decoded half-cell by half-cell, and the bench checks that the value recovered is the one present at the cell's opening edge.

// File: rtl/mce_pkg.sv
package mce_pkg;

    typedef enum logic [1:0] {
        SLOT_SYNC = 2'd0,
        SLOT_CH0  = 2'd1,
        SLOT_CH1  = 2'd2
    } slot_e;

    localparam int unsigned SLOT_COUNT = 3;

    typedef struct packed {
        logic  valid;
        slot_e slot;
        logic  value;
    } cell_req_t;

    function automatic slot_e slot_after(input slot_e s);
        case (s)
            SLOT_SYNC: return SLOT_CH0;
            SLOT_CH0:  return SLOT_CH1;
            default:   return SLOT_SYNC;
        endcase
    endfunction

    function automatic logic opening_level(input logic b);
        return ~b;
    endfunction

endpackage

// File: rtl/mce_cell_timer.sv
module mce_cell_timer #(
    parameter int unsigned CELL_CLKS = 4
) (
    input  logic clk,
    input  logic run,
    output logic cell_start,
    output logic cell_first,
    output logic mid_point
);
    localparam int unsigned PH_W = (CELL_CLKS > 2) ? $clog2(CELL_CLKS) : 1;
    localparam int unsigned HALF = CELL_CLKS / 2;
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(CELL_CLKS - 1);
    localparam logic [PH_W-1:0] MID_PH  = PH_W'(HALF - 1);

    logic            started_q;
    logic [PH_W-1:0] phase_q;

    assign cell_first = run && !started_q;
    assign cell_start = run && (!started_q || phase_q == LAST_PH);
    assign mid_point  = run && started_q && phase_q == MID_PH;

    always_ff @(posedge clk) begin
        if (!run) begin
            started_q <= 1'b0;
            phase_q   <= '0;
        end else if (cell_start) begin
            started_q <= 1'b1;
            phase_q   <= '0;
        end else begin
            phase_q   <= phase_q + 1'b1;
        end
    end

    AST_CELL_WRAP: assert property (@(posedge clk) disable iff (!run) (started_q && phase_q == LAST_PH) |=> (phase_q == '0)); // R2
    AST_FIRST_CELL: assert property (@(posedge clk) disable iff (!run) cell_first |=> (started_q && phase_q == '0)); // R8

endmodule

// File: rtl/mce_slot_sequencer.sv
module mce_slot_sequencer
    import mce_pkg::*;
(
    input  logic      clk,
    input  logic      run,
    input  logic      cell_start,
    input  logic      cell_first,
    input  logic      ch0_in,
    input  logic      ch1_in,
    output cell_req_t req,
    output logic      frame_start
);
    slot_e slot_q;
    slot_e slot_next;
    logic  sync_q;
    logic  fs_q;
    logic  pick;

    assign slot_next = cell_first ? SLOT_SYNC : slot_after(slot_q);

    always_comb begin
        case (slot_next)
            SLOT_SYNC: pick = sync_q;
            SLOT_CH0:  pick = ch0_in;
            default:   pick = ch1_in;
        endcase
    end

    assign req.valid   = cell_start;
    assign req.slot    = slot_next;
    assign req.value   = pick;
    assign frame_start = fs_q;

    always_ff @(posedge clk) begin
        if (!run) begin
            slot_q <= SLOT_SYNC;
            sync_q <= 1'b0;
            fs_q   <= 1'b0;
        end else begin
            fs_q <= cell_start && (slot_next == SLOT_SYNC);
            if (cell_start) begin
                slot_q <= slot_next;
                if (slot_next == SLOT_SYNC) begin
                    sync_q <= ~sync_q;
                end
            end
        end
    end

    AST_STROBE_ON_SYNC: assert property (@(posedge clk) disable iff (!run) frame_start |-> (slot_q == SLOT_SYNC)); // R7
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!run) frame_start |=> !frame_start); // R7
    AST_CH1_THEN_SYNC: assert property (@(posedge clk) disable iff (!run) (cell_start && !cell_first && slot_q == SLOT_CH1) |=> frame_start); // R4
    AST_FIRST_MARK_ZERO: assert property (@(posedge clk) disable iff (!run) cell_first |-> (req.value == 1'b0)); // R5

endmodule

// File: rtl/mce_line_driver.sv
module mce_line_driver
    import mce_pkg::*;
(
    input  logic      clk,
    input  logic      run,
    input  cell_req_t req,
    input  logic      mid_point,
    output logic      line_out
);
    logic bit_q;
    logic line_q;

    always_ff @(posedge clk) begin
        if (!run) begin
            bit_q  <= 1'b0;
            line_q <= 1'b0;
        end else if (req.valid) begin
            bit_q  <= req.value;
            line_q <= opening_level(req.value);
        end else if (mid_point) begin
            line_q <= bit_q;
        end
    end

    assign line_out = line_q;

    AST_SHUTDOWN_LOW: assert property (@(posedge clk) !run |=> !line_q); // R1
    AST_MID_EDGE: assert property (@(posedge clk) disable iff (!run) mid_point |=> (line_q != $past(line_q))); // R3
    AST_BIT_HELD: assert property (@(posedge clk) disable iff (!run) !req.valid |=> $stable(bit_q)); // R6

endmodule

// File: rtl/mce_frame_encoder.sv
module mce_frame_encoder
    import mce_pkg::*;
#(
    parameter int unsigned CELL_CLKS = 4
) (
    input  logic clk,
    input  logic run,
    input  logic ch0_in,
    input  logic ch1_in,
    output logic line_out,
    output logic frame_start
);
    logic      cell_start;
    logic      cell_first;
    logic      mid_point;
    cell_req_t req;

    mce_cell_timer #(.CELL_CLKS(CELL_CLKS)) u_timer (
        .clk        (clk),
        .run        (run),
        .cell_start (cell_start),
        .cell_first (cell_first),
        .mid_point  (mid_point)
    );

    mce_slot_sequencer u_seq (
        .clk         (clk),
        .run         (run),
        .cell_start  (cell_start),
        .cell_first  (cell_first),
        .ch0_in      (ch0_in),
        .ch1_in      (ch1_in),
        .req         (req),
        .frame_start (frame_start)
    );

    mce_line_driver u_drv (
        .clk       (clk),
        .run       (run),
        .req       (req),
        .mid_point (mid_point),
        .line_out  (line_out)
    );

    AST_STROBE_OFF_IN_SHUTDOWN: assert property (@(posedge clk) !run |=> !frame_start); // R1

endmodule

// File: tb/mce_frame_encoder_bench.sv
`timescale 1ns/1ps
module mce_frame_encoder_bench;

    logic clk    = 1'b0;
    logic run    = 1'b0;
    logic ch0_in = 1'b0;
    logic ch1_in = 1'b0;
    logic line_out;
    logic frame_start;

    int checks   = 0;
    int failures = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic ap0 [0:511];
    logic ap1 [0:511];

    always #2.5 clk = ~clk;

    mce_frame_encoder u_mce_frame_encoder (
        .clk         (clk),
        .run         (run),
        .ch0_in      (ch0_in),
        .ch1_in      (ch1_in),
        .line_out    (line_out),
        .frame_start (frame_start)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic shutdown(input int ncyc);
        run = 1'b0;
        for (int k = 0; k < ncyc; k++) begin
            ch0_in = ~ch0_in;
            ch1_in = ch0_in;
            @(posedge clk);
            @(negedge clk);
            chk("R1 line low in shutdown", line_out, 1'b0);
            chk("R1 strobe low in shutdown", frame_start, 1'b0);
        end
    endtask

    // mode 0: ch0=0 ch1=1, mode 1: ch0=1 ch1=0, mode 2: lfsr every clock, mode 3: counter bits
    task automatic encode_window(input int ncyc, input int mode, input bit restart);
        logic half_a;
        run = 1'b1;
        for (int c = 0; c < ncyc; c++) begin
            int n, ph, slot;
            logic b, expl;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (mode)
                0: begin ch0_in = 1'b0; ch1_in = 1'b1; end
                1: begin ch0_in = 1'b1; ch1_in = 1'b0; end
                2: begin ch0_in = lfsr[0]; ch1_in = lfsr[7]; end
                default: begin ch0_in = c[2]; ch1_in = ~c[3]; end
            endcase
            ap0[c] = ch0_in;
            ap1[c] = ch1_in;
            @(posedge clk);
            @(negedge clk);
            n    = c / 4;
            ph   = c % 4;
            slot = n % 3;
            case (slot)
                0:       b = logic'((n / 3) % 2);
                1:       b = ap0[4 * n];
                default: b = ap1[4 * n];
            endcase
            expl = (ph < 2) ? ~b : b;
            if (restart && n == 0)
                chk("R8 restart cell level", line_out, expl);
            else
                chk("R2/R3 cell level", line_out, expl);
            chk("R7 frame strobe", frame_start, (ph == 0 && slot == 0));
            if (ph == 1) half_a = line_out;
            if (ph == 3) begin
                chk("R3 midpoint transition", half_a != line_out, 1'b1);
                case (slot)
                    0:       chk("R5 marker bit", line_out, b);
                    1:       chk("R6 ch0 recovered", line_out, ap0[4 * n]);
                    default: chk("R6 ch1 recovered", line_out, ap1[4 * n]);
                endcase
                chk("R4 slot order", slot == (n % 3), 1'b1);
            end
        end
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        shutdown(6);
        encode_window(96, 0, 1'b0);
        shutdown(3);
        encode_window(96, 1, 1'b1);
        shutdown(3);
        encode_window(240, 2, 1'b1);
        shutdown(3);
        encode_window(120, 3, 1'b1);
        for (int len = 20; len < 32; len++) begin
            shutdown(2);
            encode_window(len, len % 4, 1'b1);
        end
        shutdown(4);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule